// File: doc/BRIEF.md
# Gated Frequency Counter with Scanned Display

This block measures how often a test signal rises. The test input is brought into the system clock domain by a two-flop synchroniser, and every 0-to-1 transition of the synchronised value is counted twice. One counter runs freely and is only cleared by reset. The other is cleared at the end of each programmable gate window, and its last total is kept in a holding register.

A host writes configuration words through a single-cycle write strobe. Each write carries a word index, byte enables and 32 bits of data. Both counts are always visible on two read outputs.

The block also drives a nine-column multiplexed seven-segment display. In one mode the display shows the held count in decimal. In the other mode it shows nine hex digits and nine decimal points written by the host. The block stores the divider for an external serial transmitter and presents it with a lower limit applied.

Top module: `freq_counter_top`

## Requirements
- R1: A write takes effect only when `wr_en` is high and all four byte enables are set. Any write with fewer enables is ignored. Writes to indices 6 to 15 change nothing. The writable indices are:
  - 0: divider
  - 1: gate length
  - 2: mode, bit 0
  - 3: digits 7..0, one nibble each, digit 0 in bits 3:0
  - 4: digit 8, bits 3:0
  - 5: decimal points, bit i belongs to digit i, 9 bits
- R2: `baud_div` equals the stored divider, or 4 when the stored value is below 4.
- R3: If `sample_in` rises before clock edge k, `cont_count` shows the increment after edge k+2.
- R4: `cont_count` grows by exactly one for each synchronised rising edge and is never cleared except by reset.
- R5: With P = gate length, or 1 when the gate length is 0, `per_count` is loaded every P cycles with the number of rising edges counted since the previous load, including the edge seen on the load cycle. The gate counter restarts on that same cycle.
- R6: `col_drv` is one-hot and active high. Column 0 is lit first after reset. Each column stays lit for `SCAN_CYCLES` cycles, and the columns step 0,1,...,8 and then wrap to 0.
- R7: `seg_drv` bits 6:0 drive segments a..g and are active high. Bit 7 is the decimal point of the lit digit. The glyphs for digit values 0 to F, in hex, are:
  - 0=3F, 1=06, 2=5B, 3=4F
  - 4=66, 5=6D, 6=7D, 7=07
  - 8=7F, 9=6F, A=77, B=7C
  - C=39, D=5E, E=79, F=71
- R8: When mode is 1, lit digit i shows nibble i of index 3 for i below 8, and index 4 for digit 8. The change is visible in the cycle after the write.
- R9: When mode is 0, lit digit i shows decimal digit i of `per_count`, counting from the least significant digit. Leading zeros appear as 0 and values above 999,999,999 show all nines. The display follows a new held count within 70 cycles.
- R10: A synchronous active-high reset clears every counter and register. After reset both counts are 0, `baud_div` is 4 and column 0 is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_idx | input | 4 | Word index of the register written |
| wr_be | input | 4 | Byte enables; all must be set for a write to apply |
| wr_data | input | 32 | Write data |
| sample_in | input | 1 | Asynchronous signal under test |
| per_count | output | 32 | Held count of the last gate window |
| cont_count | output | 32 | Free-running edge count |
| baud_div | output | 32 | Serial clock divider with the lower limit applied |
| col_drv | output | 9 | Column drivers, one-hot |
| seg_drv | output | 8 | Segment drivers, decimal point in bit 7 |

## Verification
A gate length of 0 makes the block capture on every cycle. A design that did not treat 0 as 1 would wait roughly four billion cycles before the first load, so `per_count` would stay frozen. An edge that lands on the capture cycle must go into the closing window. A design that dropped it or carried it over would show totals that are one too low, or drift between windows.

Narrow writes, and writes to the read-only indices, are issued between real writes. A decoder that ignored the byte enables would let a divider of 50 replace 100. The three-cycle input latency and the decimal digits shown after a capture are checked against a model that runs beside the design.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
  localparam logic [3:0] IDX_DIV  = 4'd0;
  localparam logic [3:0] IDX_GATE = 4'd1;
  localparam logic [3:0] IDX_MODE = 4'd2;
  localparam logic [3:0] IDX_DLO  = 4'd3;
  localparam logic [3:0] IDX_DHI  = 4'd4;
  localparam logic [3:0] IDX_DP   = 4'd5;

  function automatic longint unsigned pow10(input int n);
    longint unsigned r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  // segments a..g in bits 0..6
  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'h0: glyph = 7'h3F; 4'h1: glyph = 7'h06; 4'h2: glyph = 7'h5B; 4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66; 4'h5: glyph = 7'h6D; 4'h6: glyph = 7'h7D; 4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F; 4'h9: glyph = 7'h6F; 4'hA: glyph = 7'h77; 4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39; 4'hD: glyph = 7'h5E; 4'hE: glyph = 7'h79; default: glyph = 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/fc_edge_count.sv
`timescale 1ns/1ps
module fc_edge_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_in,
  input  logic [W-1:0] gate_len,
  output logic [W-1:0] per_count,
  output logic [W-1:0] cont_count
);
  logic [1:0]   sync_q;
  logic         last_q;
  logic         rise;
  logic [W-1:0] tick_q, acc_q, limit;

  assign rise  = sync_q[1] & ~last_q;
  assign limit = (gate_len == '0) ? '0 : gate_len - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '0;
      last_q     <= 1'b0;
      tick_q     <= '0;
      acc_q      <= '0;
      per_count  <= '0;
      cont_count <= '0;
    end else begin
      sync_q     <= {sync_q[0], sample_in};
      last_q     <= sync_q[1];
      cont_count <= cont_count + W'(rise);
      // >= keeps a shortened gate from waiting for a full wrap
      if (tick_q >= limit) begin
        per_count <= acc_q + W'(rise);
        acc_q     <= '0;
        tick_q    <= '0;
      end else begin
        acc_q  <= acc_q + W'(rise);
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_bcd.sv
`timescale 1ns/1ps
module fc_bcd
  import fc_pkg::*;
#(
  parameter int W  = 32,
  parameter int ND = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    bin_in,
  output logic [4*ND-1:0] dec_out
);
  localparam longint unsigned LIMIT = pow10(ND) - 1;
  localparam int IW = $clog2(W + 1);

  logic [W-1:0]    sh_q, clip;
  logic [4*ND-1:0] acc_q, acc_adj, acc_nxt;
  logic [IW-1:0]   step_q;

  assign clip = (64'(bin_in) > LIMIT) ? W'(LIMIT) : bin_in;

  always_comb begin
    acc_adj = acc_q;
    for (int d = 0; d < ND; d++) begin
      if (acc_q[4*d +: 4] >= 4'd5) acc_adj[4*d +: 4] = acc_q[4*d +: 4] + 4'd3;
    end
    acc_nxt = {acc_adj[4*ND-2:0], sh_q[W-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      acc_q   <= '0;
      step_q  <= '0;
      dec_out <= '0;
    end else if (step_q == '0) begin
      sh_q   <= clip;
      acc_q  <= '0;
      step_q <= IW'(1);
    end else begin
      sh_q  <= sh_q << 1;
      acc_q <= acc_nxt;
      if (step_q == IW'(W)) begin
        dec_out <= acc_nxt;
        step_q  <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_scan.sv
`timescale 1ns/1ps
module fc_scan
  import fc_pkg::*;
#(
  parameter int ND   = 9,
  parameter int SCAN = 1024
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4*ND-1:0] digits,
  input  logic [ND-1:0]   points,
  output logic [ND-1:0]   col,
  output logic [7:0]      seg
);
  localparam int SW = (SCAN > 1) ? $clog2(SCAN) : 1;
  localparam int DW = (ND > 1) ? $clog2(ND) : 1;

  logic [SW-1:0] cnt_q;
  logic [DW-1:0] dig_q;

  assign col = ND'(1) << dig_q;
  assign seg = {points[dig_q], glyph(digits[4*dig_q +: 4])};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dig_q <= '0;
    end else if (cnt_q == SW'(SCAN - 1)) begin
      cnt_q <= '0;
      dig_q <= (dig_q == DW'(ND - 1)) ? '0 : dig_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/freq_counter_top.sv
`timescale 1ns/1ps
module freq_counter_top
  import fc_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SCAN_CYCLES = 1024,
  parameter int MIN_DIV     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW/8-1:0] wr_be,
  input  logic [DW-1:0] wr_data,
  input  logic          sample_in,
  output logic [DW-1:0] per_count,
  output logic [DW-1:0] cont_count,
  output logic [DW-1:0] baud_div,
  output logic [8:0]    col_drv,
  output logic [7:0]    seg_drv
);
  localparam int ND = 9;
  localparam int LW = 4 * (ND - 1);

  logic [DW-1:0]   div_q, gate_q;
  logic            mode_q;
  logic [LW-1:0]   dlo_q;
  logic [3:0]      dhi_q;
  logic [ND-1:0]   dp_q;
  logic            full_wr;
  logic [4*ND-1:0] bcd_digits, shown;

  assign full_wr  = wr_en & (&wr_be);
  assign baud_div = (div_q < DW'(MIN_DIV)) ? DW'(MIN_DIV) : div_q;
  assign shown    = mode_q ? {dhi_q, dlo_q} : bcd_digits;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      gate_q <= '0;
      mode_q <= 1'b0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      dp_q   <= '0;
    end else if (full_wr) begin
      case (wr_idx)
        IDX_DIV:  div_q  <= wr_data;
        IDX_GATE: gate_q <= wr_data;
        IDX_MODE: mode_q <= wr_data[0];
        IDX_DLO:  dlo_q  <= wr_data[LW-1:0];
        IDX_DHI:  dhi_q  <= wr_data[3:0];
        IDX_DP:   dp_q   <= wr_data[ND-1:0];
        default: ;
      endcase
    end
  end

  fc_edge_count #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .sample_in(sample_in), .gate_len(gate_q),
    .per_count(per_count), .cont_count(cont_count)
  );

  fc_bcd #(.W(DW), .ND(ND)) u_bcd (
    .clk(clk), .rst(rst), .bin_in(per_count), .dec_out(bcd_digits)
  );

  fc_scan #(.ND(ND), .SCAN(SCAN_CYCLES)) u_scan (
    .clk(clk), .rst(rst), .digits(shown), .points(dp_q),
    .col(col_drv), .seg(seg_drv)
  );
endmodule

// File: rtl/fc_chk.sv
`timescale 1ns/1ps
module fc_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [3:0]    wr_idx,
  input logic [DW/8-1:0] wr_be,
  input logic [DW-1:0] baud_div,
  input logic [DW-1:0] cont_count,
  input logic [8:0]    col_drv
);
  // R2
  baud_floor_chk: assert property (@(posedge clk) disable iff (rst)
    baud_div >= DW'(4));

  // R1
  narrow_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(&wr_be) && wr_idx == 4'd0) |=> $stable(baud_div));

  // R4
  cont_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cont_count == $past(cont_count)) || (cont_count == $past(cont_count) + 1'b1));

  // R6
  col_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(col_drv) == 1);

  // R6
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (col_drv == $past(col_drv)) || (col_drv == {$past(col_drv[7:0]), $past(col_drv[8])}));
endmodule

bind freq_counter_top fc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be),
  .baud_div(baud_div), .cont_count(cont_count), .col_drv(col_drv)
);

// File: tb/sim_freq_counter_top.sv
`timescale 1ns/1ps
module sim_freq_counter_top;
  localparam int SC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        sample_in = 1'b0;
  logic [31:0] per_count, cont_count, baud_div;
  logic [8:0]  col_drv;
  logic [7:0]  seg_drv;

  always #5 clk = ~clk;

  freq_counter_top #(.SCAN_CYCLES(SC)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be),
    .wr_data(wr_data), .sample_in(sample_in), .per_count(per_count),
    .cont_count(cont_count), .baud_div(baud_div), .col_drv(col_drv), .seg_drv(seg_drv)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  byte unsigned glyph_tab [16] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07,
                                   8'h7F, 8'h6F, 8'h77, 8'h7C, 8'h39, 8'h5E, 8'h79, 8'h71};

  // behavioural reference state
  longint m_div, m_gate, m_mode, m_dlo, m_dhi, m_dp;
  longint m_hold, m_acc, m_cont, m_gcnt;
  int     m_sc, m_dig, m_stable;
  bit     hist [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint exp_seg();
    longint v;
    longint dv;
    if (m_mode == 1) begin
      dv = (m_dig < 8) ? ((m_dlo >> (4 * m_dig)) & 15) : m_dhi;
    end else begin
      v = (m_hold > 999999999) ? 999999999 : m_hold;
      for (int i = 0; i < m_dig; i++) v = v / 10;
      dv = v % 10;
    end
    return (((m_dp >> m_dig) & 1) << 7) | longint'(glyph_tab[dv]);
  endfunction

  always @(posedge clk) begin
    bit rise;
    longint p;
    if (rst) begin
      m_div = 0; m_gate = 0; m_mode = 0; m_dlo = 0; m_dhi = 0; m_dp = 0;
      m_hold = 0; m_acc = 0; m_cont = 0; m_gcnt = 0;
      m_sc = 0; m_dig = 0; m_stable = 1000;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      rise = hist[1] && !hist[2];
      m_cont += rise;
      p = (m_gate == 0) ? 1 : m_gate;
      if (m_gcnt >= p - 1) begin
        if (m_acc + rise != m_hold) m_stable = 0; else m_stable++;
        m_hold = m_acc + rise; m_acc = 0; m_gcnt = 0;
      end else begin
        m_acc += rise; m_gcnt++; m_stable++;
      end
      hist.push_front(sample_in);
      void'(hist.pop_back());
      if (m_sc == SC - 1) begin
        m_sc = 0; m_dig = (m_dig == 8) ? 0 : m_dig + 1;
      end else m_sc++;
      if (wr_en && wr_be == 4'hF) begin
        case (wr_idx)
          4'd0: m_div = wr_data;
          4'd1: m_gate = wr_data;
          4'd2: m_mode = wr_data[0];
          4'd3: m_dlo = wr_data;
          4'd4: m_dhi = wr_data[3:0];
          4'd5: m_dp = wr_data[8:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(per_count == m_hold[31:0], "R5 per_count", per_count, m_hold);
      chk(cont_count == m_cont[31:0], "R4 cont_count", cont_count, m_cont);
      chk(baud_div == ((m_div < 4) ? 32'd4 : m_div[31:0]), "R2 baud_div", baud_div, (m_div < 4) ? 4 : m_div);
      chk(col_drv == 9'(1 << m_dig), "R6 col_drv", col_drv, 1 << m_dig);
      if (m_mode == 1)
        chk(seg_drv == 8'(exp_seg()), "R8 R7 host digits", seg_drv, exp_seg());
      else if (m_stable >= 100)
        chk(seg_drv == 8'(exp_seg()), "R9 R7 count digits", seg_drv, exp_seg());
    end
  end

  task automatic wr(input logic [3:0] i, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_idx = i; wr_data = d; wr_be = be;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic wave(input int half, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      sample_in = ((i / half) % 2) == 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] base;
    // R10 reset state, sampled while reset is held
    repeat (4) @(negedge clk);
    chk(cont_count == 0, "R10 cont reset", cont_count, 0);
    chk(per_count == 0, "R10 per reset", per_count, 0);
    chk(baud_div == 4, "R10 baud reset", baud_div, 4);
    chk(col_drv == 9'd1, "R10 col reset", col_drv, 1);
    #1 rst = 1'b0;

    wr(4'd0, 32'd2, 4'hF);             // clamps
    wr(4'd0, 32'd100, 4'hF);
    wr(4'd0, 32'd50, 4'h7);            // narrow, ignored
    @(negedge clk);
    chk(baud_div == 32'd100, "R1 narrow write", baud_div, 100);
    wr(4'd0, 32'd50, 4'h0);
    wr(4'd6, 32'd123, 4'hF);
    wr(4'd7, 32'd55, 4'hF);
    wr(4'd12, 32'd9, 4'hF);
    @(negedge clk);
    chk(baud_div == 32'd100, "R1 ignored indices", baud_div, 100);

    wave(1, 20);                       // gate 0 behaves as 1
    wr(4'd1, 32'd10, 4'hF);
    wave(1, 50);
    wave(3, 60);
    wave(7, 80);
    wr(4'd1, 32'd3, 4'hF);
    wave(2, 40);

    // R3 latency
    sample_in = 1'b0;
    idle(5);
    base = cont_count;
    #1 sample_in = 1'b1;
    @(negedge clk);
    chk(cont_count == base, "R3 after edge k", cont_count, base);
    @(negedge clk);
    chk(cont_count == base, "R3 after edge k+1", cont_count, base);
    @(negedge clk);
    chk(cont_count == base + 1, "R3 after edge k+2", cont_count, base + 1);

    // host-written digits
    wr(4'd3, 32'h76543210, 4'hF);
    wr(4'd4, 32'd8, 4'hF);
    wr(4'd5, 32'h155, 4'hF);
    wr(4'd2, 32'd1, 4'hF);
    idle(40);
    wr(4'd3, 32'hFEDCBA98, 4'hF);
    wr(4'd4, 32'h0000000D, 4'hF);
    wr(4'd5, 32'h0AA, 4'hF);
    idle(40);
    wr(4'd3, 32'h11111111, 4'h3);      // narrow, ignored
    idle(40);

    // measured count on the display
    wr(4'd2, 32'd0, 4'hF);
    wr(4'd5, 32'h0, 4'hF);
    wr(4'd1, 32'd400, 4'hF);
    wave(2, 1300);
    wr(4'd1, 32'd30000, 4'hF);
    wave(1, 31000);
    sample_in = 1'b0;
    idle(5000);
    wr(4'd5, 32'h1FF, 4'hF);
    idle(400);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule